// File: doc/BRIEF.md
# Programmable Clock Divider Channel

This block divides one fast input clock down for a single output channel. Two 4-bit fields set the length of the high phase and the length of the low phase separately. Each field holds one less than the number of input cycles it stands for. A chip-level synchronization input holds the divider at a chosen start level. When that input is released, the divider waits a programmable number of cycles and then begins counting. Each channel can opt out of synchronization.

The output does not have to come from the counters. It can be forced to a static high level. It can also carry the input clock undivided, or one of two routed clocks through a direct path, or be held low while the channel is powered down. For the one setting whose period is odd and whose phases differ by a single cycle, an optional duty-cycle correction adds half an input cycle to the high phase, which gives an exact 50% waveform. All controls are plain register-field inputs.

Top module: `clk_div_channel`

## Requirements
- R1: While reset is asserted the output is low. After reset the divider runs at once and starts in its low phase. A low-count value N keeps the output low for N+1 input cycles.
- R2: A high-count value M keeps the output high for M+1 input cycles.
- R3: When the correction-disable bit is 0 and the low count equals the high count plus one, the high phase lasts M+1.5 cycles and the low phase lasts N+0.5 cycles. With the disable bit at 1, or with any other pair of counts, the phase widths stay as R1 and R2 give them.
- R4: When the sync input is 1 and the ignore bit is 0, the counters are cleared and the output is held at the start level. When the ignore bit is 1, the sync input has no effect and the divider keeps toggling.
- R5: The start-high bit picks the first phase: 1 means high, 0 means low. Call the first input clock edge that sees sync released edge 1. The first output change happens on edge offset+L+1, where L is the count field of the first phase.
- R6: When the ignore bit and the force bit are both 1, the output is static high. When the ignore bit is 0, the force bit has no effect.
- R7: When the bypass bit is 1, the output follows the divider input clock.
- R8: When the direct bit is 1, route code 2'b10 passes the VCO clock to the output and 2'b00 passes the external clock. Codes 2'b01 and 2'b11 leave the divider path in use. A direct route takes precedence over bypass and over forcing.
- R9: Power-down holds the output low and overrides every other control. While powered down, the counters are held as they are during a sync. When power-down is released, the divider restarts as it does after a sync release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Divider input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncReq | input | 1 | Chip-level synchronization, active high |
| vcoClk | input | 1 | Routed VCO clock for the direct path |
| extClk | input | 1 | Routed external clock for the direct path |
| lowCount | input | 4 | Low-phase cycles minus one |
| highCount | input | 4 | High-phase cycles minus one |
| phaseOffset | input | 4 | Cycles to wait after sync release |
| startHigh | input | 1 | First phase is high when 1 |
| ignoreSync | input | 1 | Channel ignores syncReq when 1 |
| forceHigh | input | 1 | Static high output (needs ignoreSync) |
| bypassEn | input | 1 | Pass clkIn straight through |
| directEn | input | 1 | Enable the direct route |
| routeSel | input | 2 | Direct-route source code |
| dccDisable | input | 1 | Turns duty-cycle correction off when 1 |
| powerDown | input | 1 | Channel power-down |
| divOut | output | 1 | Channel output |

## Verification
The bench builds the block with its default parameters: 4-bit count and offset fields, with the correction stage generated. At that size the bench can sweep all 256 pairs of high and low counts. It measures every phase width at half-cycle resolution, so the extra half cycle added by the correction is visible. Directed cases cover the first-toggle edge for several offsets and start levels, and the priority between power-down, the direct route, bypass and forcing.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

  typedef struct packed {
    logic holdLoad;   // clear counters, load start level
    logic offsetRun;  // phase-offset countdown in progress
    logic countRun;   // phase counters advance
  } divStrobe_t;

  typedef enum logic [1:0] {
    SRC_EXT = 2'b00,
    SRC_DIV = 2'b01,
    SRC_VCO = 2'b10,
    SRC_RSV = 2'b11
  } routeSrc_t;

endpackage

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl
  import clk_div_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             syncReq,
  input  logic             ignoreSync,
  input  logic             powerDown,
  input  logic [OFF_W-1:0] phaseOffset,
  output divStrobe_t       strobes
);

  logic [OFF_W-1:0] offCnt;
  logic             holdNow;

  assign holdNow = powerDown | (syncReq & ~ignoreSync);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
    end else if (holdNow) begin
      offCnt <= phaseOffset;
    end else if (offCnt != '0) begin
      offCnt <= offCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.holdLoad  = holdNow;
    strobes.offsetRun = !holdNow && (offCnt != '0);
    strobes.countRun  = !holdNow && (offCnt == '0);
  end

  AST_OFFSET_DEC: assert property (@(posedge clkIn) disable iff (!rstN)
    strobes.offsetRun |=> offCnt == $past(offCnt) - 1'b1); // R5

  AST_STROBE_EXCL: assert property (@(posedge clkIn) disable iff (!rstN)
    $onehot({strobes.holdLoad, strobes.offsetRun, strobes.countRun})); // R4

endmodule

// File: rtl/clk_div_path.sv
module clk_div_path
  import clk_div_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter bit HAS_DCC = 1'b1
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  divStrobe_t       strobes,
  input  logic             startHigh,
  input  logic [CNT_W-1:0] highCount,
  input  logic [CNT_W-1:0] lowCount,
  input  logic             dccOn,
  output logic             levelOut,
  output logic             pathOut
);

  logic [CNT_W-1:0] cnt;
  logic             levelReg;
  logic [CNT_W-1:0] limit;
  logic             stretch;

  assign limit = levelReg ? highCount : lowCount;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      levelReg <= 1'b0;
      cnt      <= '0;
    end else if (strobes.holdLoad) begin
      levelReg <= startHigh;
      cnt      <= '0;
    end else if (strobes.countRun) begin
      if (cnt >= limit) begin
        levelReg <= ~levelReg;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  generate
    if (HAS_DCC) begin : gDcc
      logic lateLevel;
      always_ff @(negedge clkIn or negedge rstN) begin
        if (!rstN) lateLevel <= 1'b0;
        else       lateLevel <= levelReg;
      end
      assign stretch = dccOn & lateLevel;
    end else begin : gNoDcc
      assign stretch = 1'b0;
    end
  endgenerate

  assign levelOut = levelReg;
  assign pathOut  = levelReg | stretch;

  AST_OFFSET_FREEZE: assert property (@(posedge clkIn) disable iff (!rstN)
    strobes.offsetRun |=> $stable(levelReg)); // R5

  AST_HOLD_CLEAR: assert property (@(posedge clkIn) disable iff (!rstN)
    strobes.holdLoad |=> cnt == '0); // R4

endmodule

// File: rtl/clk_div_channel.sv
module clk_div_channel
  import clk_div_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int OFF_W   = 4,
  parameter bit HAS_DCC = 1'b1
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             syncReq,
  input  logic             vcoClk,
  input  logic             extClk,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic [OFF_W-1:0] phaseOffset,
  input  logic             startHigh,
  input  logic             ignoreSync,
  input  logic             forceHigh,
  input  logic             bypassEn,
  input  logic             directEn,
  input  logic [1:0]       routeSel,
  input  logic             dccDisable,
  input  logic             powerDown,
  output logic             divOut
);

  localparam int CW1 = CNT_W + 1;

  divStrobe_t strobes;
  logic       dccOn;
  logic       pathLevel;
  logic       pathOut;
  logic       directVco;
  logic       directExt;
  logic       forceOn;
  routeSrc_t  srcSel;

  assign srcSel  = routeSrc_t'(routeSel);
  assign dccOn   = !dccDisable &&
                   ({1'b0, lowCount} == ({1'b0, highCount} + CW1'(1)));
  assign directVco = directEn && (srcSel == SRC_VCO);
  assign directExt = directEn && (srcSel == SRC_EXT);
  assign forceOn   = ignoreSync && forceHigh;

  clk_div_ctrl #(.OFF_W(OFF_W)) uCtrl (
    .clkIn       (clkIn),
    .rstN        (rstN),
    .syncReq     (syncReq),
    .ignoreSync  (ignoreSync),
    .powerDown   (powerDown),
    .phaseOffset (phaseOffset),
    .strobes     (strobes)
  );

  clk_div_path #(.CNT_W(CNT_W), .HAS_DCC(HAS_DCC)) uPath (
    .clkIn     (clkIn),
    .rstN      (rstN),
    .strobes   (strobes),
    .startHigh (startHigh),
    .highCount (highCount),
    .lowCount  (lowCount),
    .dccOn     (dccOn),
    .levelOut  (pathLevel),
    .pathOut   (pathOut)
  );

  always_comb begin
    if (powerDown)      divOut = 1'b0;
    else if (directVco) divOut = vcoClk;
    else if (directExt) divOut = extClk;
    else if (bypassEn)  divOut = clkIn;
    else if (forceOn)   divOut = 1'b1;
    else                divOut = pathOut;
  end

  AST_PWRDN_LOW: assert property (@(posedge clkIn) disable iff (!rstN)
    powerDown |-> !divOut); // R9

  AST_FORCE_STATIC: assert property (@(posedge clkIn) disable iff (!rstN)
    (forceOn && !powerDown && !directEn && !bypassEn) |-> divOut); // R6

  AST_SYNC_START: assert property (@(posedge clkIn) disable iff (!rstN)
    (syncReq && !ignoreSync) |=> pathLevel == $past(startHigh)); // R4

endmodule

// File: tb/clk_div_channel_test.sv
`timescale 1ns/1ps
module clk_div_channel_test;

  logic       clkIn = 1'b0;
  logic       rstN;
  logic       syncReq, vcoClk, extClk;
  logic [3:0] lowCount, highCount, phaseOffset;
  logic       startHigh, ignoreSync, forceHigh, bypassEn, directEn;
  logic [1:0] routeSel;
  logic       dccDisable, powerDown;
  logic       divOut;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    bit    lvl;
    int    halves;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  bit monEn = 1'b0;

  clk_div_channel uut (
    .clkIn(clkIn), .rstN(rstN), .syncReq(syncReq), .vcoClk(vcoClk),
    .extClk(extClk), .lowCount(lowCount), .highCount(highCount),
    .phaseOffset(phaseOffset), .startHigh(startHigh),
    .ignoreSync(ignoreSync), .forceHigh(forceHigh), .bypassEn(bypassEn),
    .directEn(directEn), .routeSel(routeSel), .dccDisable(dccDisable),
    .powerDown(powerDown), .divOut(divOut)
  );

  always #10 clkIn = ~clkIn;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clkIn);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  // monitor: half-cycle run lengths compared against the queue
  initial begin
    bit started = 1'b0;
    bit skip    = 1'b1;
    bit prev    = 1'b0;
    int len     = 0;
    forever begin
      @(clkIn);
      #5;
      if (!monEn) begin
        started = 1'b0;
        skip    = 1'b1;
      end else if (!started) begin
        started = 1'b1;
        prev    = divOut;
        len     = 1;
      end else if (divOut == prev) begin
        len++;
      end else begin
        if (skip) skip = 1'b0;
        else if (expQ.size() > 0) begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.lvl == prev && it.halves == len, it.req, len, it.halves);
        end
        prev = divOut;
        len  = 1;
      end
    end
  end

  task automatic drvEdge();
    @(negedge clkIn);
    #1;
  endtask

  task automatic pushExp(input bit lvl, input int halves);
    expItem_t it;
    it.lvl    = lvl;
    it.halves = halves;
    it.req    = lvl ? "R2 high width" : "R1 low width";
    expQ.push_back(it);
  endtask

  // driver: program counts under sync, queue expected widths, release
  task automatic runWidths(input int n, input int m, input bit dccDis,
                           input int hHalves, input int lHalves, input string dccTag);
    drvEdge();
    syncReq = 1'b1; startHigh = 1'b0; lowCount = 4'(n); highCount = 4'(m);
    dccDisable = dccDis; phaseOffset = 4'd0;
    drvEdge();
    monEn = 1'b1;
    drvEdge();
    for (int k = 0; k < 2; k++) begin
      expItem_t a, b;
      a.lvl = 1'b1; a.halves = hHalves; a.req = (dccTag != "") ? dccTag : "R2 high width";
      b.lvl = 1'b0; b.halves = lHalves; b.req = (dccTag != "") ? dccTag : "R1 low width";
      expQ.push_back(a);
      expQ.push_back(b);
    end
    syncReq = 1'b0;
    while (expQ.size() != 0) @(posedge clkIn);
    repeat (2) @(posedge clkIn);
    monEn = 1'b0;
  endtask

  // releases sync (or power-down) and counts edges to the first output change
  task automatic firstToggle(input bit viaPd, output int n);
    bit startLvl;
    drvEdge();
    startLvl = divOut;
    if (viaPd) begin
      powerDown = 1'b0;
      startLvl  = startHigh;
    end else begin
      syncReq = 1'b0;
    end
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clkIn);
      #5;
      n++;
      if (divOut != startLvl) break;
    end
  endtask

  task automatic sampleHalves(input bit expHi, input bit expLo, input string req);
    @(posedge clkIn); #5;
    check(divOut == expHi, req, divOut, expHi);
    @(negedge clkIn); #5;
    check(divOut == expLo, req, divOut, expLo);
  endtask

  task automatic checkToggling(input string req);
    bit a;
    @(posedge clkIn); #5; a = divOut;
    @(posedge clkIn); #5;
    check(divOut != a, req, divOut, !a);
  endtask

  initial begin
    int n;
    rstN = 1'b0; syncReq = 1'b0; vcoClk = 1'b0; extClk = 1'b0;
    lowCount = '0; highCount = '0; phaseOffset = '0; startHigh = 1'b0;
    ignoreSync = 1'b0; forceHigh = 1'b0; bypassEn = 1'b0; directEn = 1'b0;
    routeSel = 2'b00; dccDisable = 1'b0; powerDown = 1'b0;

    // R1 reset state
    repeat (3) @(posedge clkIn);
    #5 check(divOut == 1'b0, "R1 reset low", divOut, 0);
    drvEdge();
    rstN = 1'b1;

    // R1 R2 all count pairs, correction off
    for (int lo = 0; lo < 16; lo++)
      for (int hi = 0; hi < 16; hi++)
        runWidths(lo, hi, 1'b1, 2*(hi+1), 2*(lo+1), "");

    // R3 duty-cycle correction
    runWidths(3, 2, 1'b0, 7, 7, "R3 corrected");
    runWidths(1, 0, 1'b0, 3, 3, "R3 corrected");
    runWidths(5, 2, 1'b0, 6, 12, "R3 no correction");
    runWidths(3, 2, 1'b1, 6, 8, "R3 disabled");

    // R4 hold at start level
    dccDisable = 1'b1;
    drvEdge();
    syncReq = 1'b1; startHigh = 1'b1; lowCount = 4'd2; highCount = 4'd1;
    phaseOffset = 4'd0;
    repeat (3) sampleHalves(1'b1, 1'b1, "R4 sync hold");

    // R5 first toggle after release: start high, offset 5, high 1 -> edge 7
    phaseOffset = 4'd5;
    repeat (2) @(posedge clkIn);
    firstToggle(1'b0, n);
    check(n == 7, "R5 start high offset", n, 7);

    drvEdge();
    syncReq = 1'b1; startHigh = 1'b0; lowCount = 4'd2; highCount = 4'd5;
    phaseOffset = 4'd3;
    repeat (2) @(posedge clkIn);
    firstToggle(1'b0, n);
    check(n == 6, "R5 start low offset", n, 6);

    drvEdge();
    syncReq = 1'b1; lowCount = 4'd0; phaseOffset = 4'd0;
    repeat (2) @(posedge clkIn);
    firstToggle(1'b0, n);
    check(n == 1, "R5 zero offset", n, 1);

    // R4 ignore bit
    drvEdge();
    lowCount = 4'd0; highCount = 4'd0; ignoreSync = 1'b1; syncReq = 1'b1;
    checkToggling("R4 sync ignored");
    checkToggling("R4 sync ignored");

    // R6 forcing
    drvEdge();
    forceHigh = 1'b1;
    repeat (2) sampleHalves(1'b1, 1'b1, "R6 force high");
    drvEdge();
    ignoreSync = 1'b0; syncReq = 1'b0;
    checkToggling("R6 force without ignore");

    // R7 bypass (over forcing)
    drvEdge();
    ignoreSync = 1'b1; bypassEn = 1'b1;
    repeat (2) sampleHalves(1'b1, 1'b0, "R7 bypass");

    // R8 direct route
    drvEdge();
    directEn = 1'b1; routeSel = 2'b10;
    vcoClk = 1'b1; #1 check(divOut == 1'b1, "R8 vco route", divOut, 1);
    vcoClk = 1'b0; #1 check(divOut == 1'b0, "R8 vco route", divOut, 0);
    routeSel = 2'b00;
    extClk = 1'b1; #1 check(divOut == 1'b1, "R8 ext route", divOut, 1);
    extClk = 1'b0; #1 check(divOut == 1'b0, "R8 ext route", divOut, 0);
    drvEdge();
    routeSel = 2'b01; bypassEn = 1'b0; forceHigh = 1'b0; ignoreSync = 1'b0;
    vcoClk = 1'b1;
    checkToggling("R8 code 01 divider");
    drvEdge();
    routeSel = 2'b11;
    checkToggling("R8 code 11 divider");

    // R9 power-down overrides everything
    drvEdge();
    powerDown = 1'b1; routeSel = 2'b10; bypassEn = 1'b1;
    ignoreSync = 1'b1; forceHigh = 1'b1;
    repeat (2) sampleHalves(1'b0, 1'b0, "R9 power-down low");
    drvEdge();
    directEn = 1'b0; bypassEn = 1'b0; ignoreSync = 1'b0; forceHigh = 1'b0;
    startHigh = 1'b0; lowCount = 4'd4; phaseOffset = 4'd0;
    repeat (2) @(posedge clkIn);
    firstToggle(1'b1, n);
    check(n == 5, "R9 restart after power-down", n, 5);

    finishRun();
  end

endmodule